// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Level and Character Timeout

This block is the receive side storage of a 16550-style serial port. Bytes arrive from a deserialiser one at a time, together with break events. They are held in a 16-entry byte queue, or in a single holding slot while the queue is switched off. The host drains the bytes through a read strobe. The block keeps data-ready, overrun and break status, reports the occupancy, and raises a trigger flag once the occupancy reaches a level chosen through a FIFO control write.

A timeout timer counts baud-rate oversample enables, 16 per bit time. It raises a timeout-pending flag once the line has been quiet for four character times while data is still waiting. The character length is worked out from the frame settings. A FIFO control write can flush the queue, and flipping the FIFO enable bit always flushes it. A status-read strobe clears the sticky overrun and break flags.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the queue is empty, all flags are low, `rd_data_o` is 0x00, the FIFO is disabled (single holding slot) and the trigger selection is 0.
- R2: `fcr_data_i[7:6]` written with `fcr_we_i` select the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. With the FIFO enabled, `trigger_o` is high exactly when `count_o` is at least that level. With the FIFO disabled it follows `data_ready_o`.
- R3: With the FIFO enabled, bytes leave in arrival order. Up to 16 are held. A byte arriving while 16 are held and no read happens in that cycle is dropped, the stored bytes are kept, and `overrun_o` is set.
- R4: A read (`rd_i`) presents the oldest byte on `rd_data_o` in the cycle of the strobe and removes it. With nothing stored, `rd_data_o` is 0x00. A read that leaves the buffer empty clears `data_ready_o` and `break_o`.
- R5: A break event (`brk_i`) stores a 0x00 byte as a received byte would, and sets `break_o` and `data_ready_o`. In the same cycle it takes precedence over `rx_valid_i`.
- R6: A control write with `fcr_data_i[1]` set empties the buffer and clears data-ready, break and timeout-pending, and it stops the timer. A write whose `fcr_data_i[0]` differs from the current enable does the same. A write with the same enable and bit 1 clear keeps the contents. Receive, break and read strobes in the cycle of a control write are ignored.
- R7: With the FIFO disabled, a byte arriving while a byte is held replaces it and sets `overrun_o`.
- R8: The timeout period is 16 x 4 x F cycles of `baud_en_i`, where F = 1 + (5 + `frame_cfg_i[1:0]`) + `frame_cfg_i[3]` (parity) + (`frame_cfg_i[2]` ? 2 : 1). `timeout_o` rises at the baud enable that completes the period.
- R9: In FIFO mode the timer restarts on every received byte or break, and on every read that leaves data behind. `timeout_o` is set at expiry only if the buffer holds data. A read clears it.
- R10: A status read (`lsr_rd_i`) clears `overrun_o` and `break_o`. A new overrun or break in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_en_i | input | 1 | 16x oversample enable |
| frame_cfg_i | input | 4 | [1:0] data length - 5, [2] two stop bits, [3] parity enable |
| fcr_we_i | input | 1 | FIFO control write strobe |
| fcr_data_i | input | 8 | [0] FIFO enable, [1] receive flush, [7:6] trigger select |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| brk_i | input | 1 | Break event strobe |
| rd_i | input | 1 | Host data read strobe |
| lsr_rd_i | input | 1 | Host status read strobe |
| rd_data_o | output | 8 | Oldest byte, 0x00 when empty |
| data_ready_o | output | 1 | Buffer holds data |
| overrun_o | output | 1 | Sticky overrun flag |
| break_o | output | 1 | Sticky break flag |
| count_o | output | $clog2(DEPTH+1) (5) | Occupancy |
| trigger_o | output | 1 | Occupancy at or above trigger level |
| timeout_o | output | 1 | Character timeout pending |

## Verification
The bench sweeps all four trigger selections. At each it fills the queue one byte at a time to full, then pushes one byte more. A design that overwrote on overrun would return the extra byte on readback, and an off-by-one trigger compare would flip `trigger_o` one byte early or late. All sixteen frame settings are swept with the timeout counted to the exact cycle. A wrong frame-length sum or a missed timer restart on a read would move the edge of `timeout_o`. The bench also lets the timer expire on an empty buffer, where a design that ignored occupancy would raise a spurious timeout. It then checks that a same-enable control write keeps the data while an enable flip flushes it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_FRAME_BITS = 12;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 5'd1;
      2'd1:    trig_level = 5'd4;
      2'd2:    trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction

  // start + data + parity + stop
  function automatic logic [3:0] frame_bits(input logic [3:0] cfg);
    frame_bits = 4'd6 + {2'b00, cfg[1:0]} + {3'b000, cfg[3]} + (cfg[2] ? 4'd2 : 4'd1);
  endfunction
endpackage

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          ovw_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      if (push_i)     mem[wr_ptr] <= wdata_i;
      else if (ovw_i) mem[rd_ptr] <= wdata_i;
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count_q;
endmodule

// File: rtl/rx_timeout_timer.sv
module rx_timeout_timer #(
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          stop_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;
  logic          run_q;

  assign expire_o = run_q && tick_i && (cnt_q >= limit_i - 1'b1) && !restart_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (stop_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (expire_o) begin
      run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rx_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int OVERSAMPLE    = 16,
  parameter int TIMEOUT_CHARS = 4,
  localparam int CW           = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud_en_i,
  input  logic [3:0]    frame_cfg_i,
  input  logic          fcr_we_i,
  input  logic [7:0]    fcr_data_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          brk_i,
  input  logic          rd_i,
  input  logic          lsr_rd_i,
  output logic [7:0]    rd_data_o,
  output logic          data_ready_o,
  output logic          overrun_o,
  output logic          break_o,
  output logic [CW-1:0] count_o,
  output logic          trigger_o,
  output logic          timeout_o
);
  localparam int TMO_MAX = OVERSAMPLE * TIMEOUT_CHARS * MAX_FRAME_BITS;
  localparam int TW      = $clog2(TMO_MAX + 1);
  localparam logic [TW-1:0] SCALE = TW'(OVERSAMPLE * TIMEOUT_CHARS);

  logic          fifo_en_q, ovr_q, brk_q, tmo_q;
  logic [1:0]    trig_sel_q;
  logic [CW-1:0] count;
  logic [7:0]    head;
  logic          en_flip, flush, ev_rx, ev_brk, ev_rd;
  logic          pop, blocked, push, ovw, set_ovr, empties, restart, expire;
  logic [TW-1:0] limit;

  assign en_flip = fcr_we_i && (fcr_data_i[0] != fifo_en_q);
  assign flush   = fcr_we_i && (fcr_data_i[1] || en_flip);
  assign ev_brk  = brk_i && !fcr_we_i;
  assign ev_rx   = (rx_valid_i || brk_i) && !fcr_we_i;
  assign ev_rd   = rd_i && !fcr_we_i;

  assign pop     = ev_rd && (count != '0);
  assign blocked = (fifo_en_q ? (count == CW'(DEPTH)) : (count != '0)) && !pop;
  assign push    = ev_rx && !blocked;
  assign ovw     = ev_rx && blocked && !fifo_en_q;
  assign set_ovr = ev_rx && blocked;
  assign empties = pop && (count == CW'(1)) && !push;

  assign restart = fifo_en_q && (ev_rx || (pop && count > CW'(1)));
  assign limit   = SCALE * TW'(frame_bits(frame_cfg_i));

  rx_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .ovw_i   (ovw),
    .pop_i   (pop),
    .wdata_i (brk_i ? 8'h00 : rx_data_i),
    .head_o  (head),
    .count_o (count)
  );

  rx_timeout_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (baud_en_i),
    .restart_i (restart),
    .stop_i    (flush),
    .limit_i   (limit),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q  <= 1'b0;
      trig_sel_q <= 2'd0;
      ovr_q      <= 1'b0;
      brk_q      <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      if (fcr_we_i) begin
        fifo_en_q  <= fcr_data_i[0];
        trig_sel_q <= fcr_data_i[7:6];
      end
      if (set_ovr)       ovr_q <= 1'b1;
      else if (lsr_rd_i) ovr_q <= 1'b0;
      if (flush)                     brk_q <= 1'b0;
      else if (ev_brk)               brk_q <= 1'b1;
      else if (empties || lsr_rd_i)  brk_q <= 1'b0;
      if (flush || ev_rd)                tmo_q <= 1'b0;
      else if (expire && count != '0)    tmo_q <= 1'b1;
    end
  end

  assign rd_data_o    = (count != '0) ? head : 8'h00;
  assign data_ready_o = (count != '0);
  assign overrun_o    = ovr_q;
  assign break_o      = brk_q;
  assign count_o      = count;
  assign trigger_o    = fifo_en_q ? (count >= CW'(trig_level(trig_sel_q))) : (count != '0);
  assign timeout_o    = tmo_q;
endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic          brk_i,
  input logic          rd_i,
  input logic          lsr_rd_i,
  input logic          fcr_we_i,
  input logic [7:0]    fcr_data_i,
  input logic          fifo_en,
  input logic [CW-1:0] count_o,
  input logic          data_ready_o,
  input logic          overrun_o,
  input logic          break_o,
  input logic          timeout_o
);
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R3
  AST_OVR_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i || brk_i) && !fcr_we_i && !rd_i && fifo_en && count_o == CW'(DEPTH)
    |=> overrun_o && count_o == CW'(DEPTH)); // R3
  AST_BREAK_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i && !fcr_we_i |=> break_o && data_ready_o); // R5
  AST_RX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcr_we_i && fcr_data_i[1] |=> count_o == '0 && !timeout_o && !break_o); // R6
  AST_STATUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i && !rx_valid_i && !brk_i |=> !overrun_o && !break_o); // R10
  AST_TMO_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> count_o != '0); // R9
  AST_READ_CLEARS_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !fcr_we_i |=> !timeout_o); // R9
endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .brk_i        (brk_i),
  .rd_i         (rd_i),
  .lsr_rd_i     (lsr_rd_i),
  .fcr_we_i     (fcr_we_i),
  .fcr_data_i   (fcr_data_i),
  .fifo_en      (fifo_en_q),
  .count_o      (count_o),
  .data_ready_o (data_ready_o),
  .overrun_o    (overrun_o),
  .break_o      (break_o),
  .timeout_o    (timeout_o)
);

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_en_i = 1'b0;
  logic [3:0] frame_cfg_i = 4'd0;
  logic       fcr_we_i = 1'b0;
  logic [7:0] fcr_data_i = 8'd0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = 8'd0;
  logic       brk_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       lsr_rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       data_ready_o, overrun_o, break_o, trigger_o, timeout_o;
  logic [4:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  uart_rx_buffer u_uart_rx_buffer (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid_i = 1'b1; rx_data_i = b; step(); rx_valid_i = 1'b0;
  endtask

  task automatic brk();
    brk_i = 1'b1; step(); brk_i = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    b = rd_data_o; rd_i = 1'b1; step(); rd_i = 1'b0;
  endtask

  task automatic fcr(input logic [7:0] v);
    fcr_we_i = 1'b1; fcr_data_i = v; step(); fcr_we_i = 1'b0;
  endtask

  task automatic lsr();
    lsr_rd_i = 1'b1; step(); lsr_rd_i = 1'b0;
  endtask

  function automatic int lvl(input int sel);
    case (sel)
      0: lvl = 1;
      1: lvl = 4;
      2: lvl = 8;
      default: lvl = 14;
    endcase
  endfunction

  function automatic int period(input int c);
    period = 64 * (1 + 5 + (c % 4) + ((c >> 3) & 1) + (((c >> 2) & 1) != 0 ? 2 : 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 flags", {data_ready_o, overrun_o, break_o, trigger_o, timeout_o}, 0);
    chk("R1 rd_data", rd_data_o, 0);

    // R7 hold mode after reset
    push(8'h5A);
    chk("R7 count", count_o, 1);
    chk("R2 trig hold", trigger_o, 1);
    push(8'hA5);
    chk("R7 overrun", overrun_o, 1);
    chk("R7 count kept", count_o, 1);
    rd(b);
    chk("R7 newest kept", b, 8'hA5);
    chk("R4 dr cleared", data_ready_o, 0);
    rd(b);
    chk("R4 empty read", b, 0);
    lsr();
    chk("R10 overrun clear", overrun_o, 0);

    // R2/R3 trigger sweep, fill and overrun
    for (int sel = 0; sel < 4; sel++) begin
      fcr(8'((sel << 6) | 3));
      chk("R6 flush", count_o, 0);
      for (int n = 1; n <= 16; n++) begin
        push(8'(sel * 16 + n));
        chk("R2 trigger", trigger_o, int'(n >= lvl(sel)));
        chk("R3 count", count_o, n);
      end
      push(8'hEE);
      chk("R3 overrun", overrun_o, 1);
      chk("R3 full count", count_o, 16);
      for (int n = 1; n <= 16; n++) begin
        rd(b);
        chk("R3 order", b, sel * 16 + n);
      end
      chk("R4 dr empty", data_ready_o, 0);
      rd(b);
      chk("R4 empty zero", b, 0);
      lsr();
      chk("R10 clear", overrun_o, 0);
    end

    // R5 break
    fcr(8'h03);
    push(8'h11);
    brk();
    chk("R5 count", count_o, 2);
    chk("R5 flags", {break_o, data_ready_o}, 2'b11);
    rd(b);
    chk("R5 first byte", b, 8'h11);
    chk("R4 break held", break_o, 1);
    rd(b);
    chk("R5 zero byte", b, 0);
    chk("R4 break cleared", {break_o, data_ready_o}, 0);
    brk();
    lsr();
    chk("R10 break clear", break_o, 0);
    chk("R10 data kept", count_o, 1);

    // R6 enable handling
    fcr(8'h03);
    push(8'h01); push(8'h02); push(8'h03);
    fcr(8'h41);
    chk("R6 no flush", count_o, 3);
    chk("R2 level4 below", trigger_o, 0);
    push(8'h04);
    chk("R2 level4 reached", trigger_o, 1);
    fcr(8'h40);
    chk("R6 toggle flush", count_o, 0);
    chk("R6 dr", data_ready_o, 0);
    fcr(8'h01);
    chk("R6 toggle on flush", count_o, 0);

    // R8 timeout period sweep
    baud_en_i = 1'b1;
    for (int c = 0; c < 16; c++) begin
      frame_cfg_i = 4'(c);
      fcr(8'h03);
      push(8'h33);
      repeat (period(c) - 1) step();
      chk("R8 before expiry", timeout_o, 0);
      step();
      chk("R8 at expiry", timeout_o, 1);
      rd(b);
      chk("R9 read clears", timeout_o, 0);
    end

    // R9 restart on read with data left
    frame_cfg_i = 4'd0;
    fcr(8'h03);
    push(8'h01); push(8'h02);
    repeat (100) step();
    rd(b);
    repeat (period(0) - 1) step();
    chk("R9 restart on read", timeout_o, 0);
    step();
    chk("R9 expiry after read", timeout_o, 1);
    rd(b);
    chk("R9 cleared", {timeout_o, data_ready_o}, 0);

    // R9 empty at expiry
    push(8'h07);
    rd(b);
    repeat (period(0) + 5) step();
    chk("R9 empty no timeout", timeout_o, 0);

    // R6 flush clears timeout and break
    push(8'h08);
    brk();
    repeat (period(0)) step();
    chk("R9 pending", timeout_o, 1);
    fcr(8'h03);
    chk("R6 flush clears", {timeout_o, break_o, data_ready_o}, 0);
    repeat (period(0) + 5) step();
    chk("R6 timer stopped", timeout_o, 0);
    baud_en_i = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule